// File: doc/BRIEF.md
# Serial GPIO drive-LED shifter

This block turns per-port drive status updates into a three-wire serial stream (shift clock, load strobe, serial data) for an external enclosure LED controller. A request names a port and carries a 32-bit status word. The block decodes three indicators from the word: activity, locate and fault. It writes them into a pattern register at the position that a configurable port-to-slot table gives for that port. It then transmits the whole pattern as one frame.

A frame starts with a programmable number of idle clocks. One clock cycle follows with the load strobe high. Then three bits per configured slot are shifted out, least significant first, and a programmable number of trailing clocks ends the frame. Each serial clock cycle is high and then low for a fixed number of system clocks, set by a divider parameter. While a frame is running the block reports busy and ignores new requests. The last accepted status word of each port can be read back.

Top module: `sgpio_led_shifter`

## Requirements
- R1: While reset is applied and after its release, `sg_clk`, `sg_load`, `sg_data`, `busy`, `req_accept` and `req_error` are 0, and every port reads back status 0.
- R2: Port p owns pattern bits 3*s+0 (activity), 3*s+1 (locate) and 3*s+2 (fault), where s is the 3-bit field `cfg_slot_map[3p+2:3p]` sampled when the request is accepted. No other pattern bit changes.
- R3: Activity is 1 when status bit 20 or bit 21 is 1. Locate equals status bit 19 and fault equals status bit 22. An indicator whose bits are clear is written 0.
- R4: A request taken while idle whose status bits 15:8 are at least SUBADDR_LIMIT (default 15) raises `req_error` for one cycle. It changes neither the pattern nor the stored status, and it starts no frame.
- R5: An accepted request raises `req_accept` for one cycle. The frame it starts opens with `cfg_pre_clocks` serial clocks that have `sg_load`=0 and `sg_data`=0, followed by exactly one serial clock with `sg_load`=1 and `sg_data`=0.
- R6: After the load clock, 3*N pattern bits are sent, bit 0 first, one bit per serial clock, with `sg_load`=0. N is `cfg_n_ports`, valid from 1 to 8.
- R7: The data bits are followed by `cfg_post_clocks` serial clocks with `sg_load`=0 and `sg_data`=0. `busy` then falls, and no further serial clocks occur.
- R8: Every serial clock is high for HALF_DIV system clocks, preceded by HALF_DIV system clocks low within the frame. `sg_load` and `sg_data` change only while `sg_clk` is low.
- R9: `busy` is 1 from the accept until the frame ends. A request presented while busy gets neither `req_accept` nor `req_error`, and it leaves the pattern and the stored status unchanged.
- R10: `rd_status` shows the last accepted status word of port `rd_port`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Update request strobe |
| req_port | input | 3 | Port the request belongs to |
| req_status | input | 32 | Status word carrying indicators and sub-address |
| req_accept | output | 1 | One-cycle pulse: request taken, frame started |
| req_error | output | 1 | One-cycle pulse: request refused for bad sub-address |
| busy | output | 1 | Frame in progress; requests ignored |
| cfg_n_ports | input | 4 | Number of slots sent per frame (1..8) |
| cfg_pre_clocks | input | 8 | Idle serial clocks before the load clock |
| cfg_post_clocks | input | 8 | Idle serial clocks after the data |
| cfg_slot_map | input | 24 | Per-port 3-bit slot index |
| rd_port | input | 3 | Port selected for status readback |
| rd_status | output | 32 | Last accepted status of `rd_port` |
| sg_clk | output | 1 | Serial shift clock |
| sg_load | output | 1 | Serial load strobe |
| sg_data | output | 1 | Serial data |

## Verification
Requests use single indicator bits (bit 20 alone, bit 21 with bit 19, bit 22 alone) so that each decode path lights a distinct pattern bit, and an all-clear word shows that bits are cleared and not just left as they were. A reversed slot map and a later remap separate the port number from the slot position. Short frames with nonzero pre and post counts show that framing counts come from configuration, and that only 3*N bits go out. Sub-address values of 14 and 15 mark the accept/reject boundary. A request held up during a frame shows that it leaves no trace in the next frame or in the readback.

// File: rtl/sgpio_led_pkg.sv
package sgpio_led_pkg;

  localparam int IND_PER_SLOT = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LEAD = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

  // bit order matters: activity lands on the lowest bit of a slot triple
  typedef struct packed {
    logic fault;
    logic locate;
    logic activity;
  } led_ind_t;

  function automatic led_ind_t decode_status(input logic [31:0] st);
    led_ind_t r;
    r.activity = st[21] | st[20];
    r.locate   = st[19];
    r.fault    = st[22];
    return r;
  endfunction

endpackage

// File: rtl/sgpio_pattern_store.sv
module sgpio_pattern_store
  import sgpio_led_pkg::*;
#(
  parameter int NUM_PORTS     = 8,
  parameter int NUM_SLOTS     = 8,
  parameter int SUBADDR_LIMIT = 15,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int PAT_W  = IND_PER_SLOT * NUM_SLOTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [PORT_W-1:0]           req_port,
  input  logic [31:0]                 req_status,
  input  logic                        seq_busy,
  input  logic [NUM_PORTS*SLOT_W-1:0] slot_map,
  input  logic [PORT_W-1:0]           rd_port,
  output logic [31:0]                 rd_status,
  output logic [PAT_W-1:0]            pattern,
  output logic                        start,
  output logic                        accept_q,
  output logic                        error_q
);

  logic              take;
  logic              in_range;
  logic              accept_now;
  logic              reject_now;
  logic [SLOT_W-1:0] slot;
  led_ind_t          ind;
  logic [PAT_W-1:0]  pat_q;
  logic [PAT_W-1:0]  pat_d;
  logic [31:0]       stat_q [NUM_PORTS];
  logic [NUM_PORTS-1:0] stat_en;

  always_comb begin
    take       = req_valid && !seq_busy;
    in_range   = req_status[15:8] < 8'(SUBADDR_LIMIT);
    accept_now = take && in_range;
    reject_now = take && !in_range;
    slot       = slot_map[int'(req_port)*SLOT_W +: SLOT_W];
    ind        = decode_status(req_status);
  end

  always_comb begin
    pat_d = pat_q;
    if (accept_now) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (slot == SLOT_W'(s)) begin
          pat_d[IND_PER_SLOT*s +: IND_PER_SLOT] = ind;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q    <= '0;
      accept_q <= 1'b0;
      error_q  <= 1'b0;
    end else begin
      if (accept_now) begin
        pat_q <= pat_d;
      end
      accept_q <= accept_now;
      error_q  <= reject_now;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_stat
    assign stat_en[p] = accept_now && (req_port == PORT_W'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[p] <= '0;
      end else if (stat_en[p]) begin
        stat_q[p] <= req_status;
      end
    end
  end

  assign rd_status = stat_q[rd_port];
  assign pattern   = pat_q;
  assign start     = accept_now;

endmodule

// File: rtl/sgpio_frame_seq.sv
module sgpio_frame_seq
  import sgpio_led_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int HALF_DIV  = 5000,
  parameter int CLKCNT_W  = 8,
  localparam int PAT_W  = IND_PER_SLOT * NUM_SLOTS,
  localparam int NCFG_W = $clog2(NUM_SLOTS + 1),
  localparam int BIT_W  = $clog2(PAT_W),
  localparam int TOT_W  = CLKCNT_W + BIT_W + 2,
  localparam int PH_W   = $clog2(2 * HALF_DIV)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PAT_W-1:0]    pattern,
  input  logic [NCFG_W-1:0]   cfg_n_ports,
  input  logic [CLKCNT_W-1:0] cfg_pre,
  input  logic [CLKCNT_W-1:0] cfg_post,
  output logic                busy,
  output logic                sg_clk,
  output logic                sg_load,
  output logic                sg_data
);

  // HALF_DIV must be at least 2 so that the data update point sits strictly
  // inside the low half of a serial clock
  localparam logic [PH_W-1:0] PH_HIGH_END = PH_W'(HALF_DIV - 1);
  localparam logic [PH_W-1:0] PH_LOW_SET  = PH_W'(HALF_DIV);
  localparam logic [PH_W-1:0] PH_END      = PH_W'(2 * HALF_DIV - 1);

  seq_state_e          state_q, state_d;
  logic [PH_W-1:0]     ph_q, ph_d;
  logic [TOT_W-1:0]    bidx_q, bidx_d;
  logic [TOT_W-1:0]    pre_q, pre_d;
  logic [TOT_W-1:0]    bits_q, bits_d;
  logic [TOT_W-1:0]    last_q, last_d;
  logic                clk_q, clk_d;
  logic                load_q, load_d;
  logic                data_q, data_d;

  logic [NCFG_W-1:0]   n_cl;
  logic [TOT_W-1:0]    cfg_bits;
  logic [TOT_W-1:0]    pre_use;
  logic [TOT_W-1:0]    bits_use;
  logic [TOT_W-1:0]    sel_idx;
  logic [TOT_W-1:0]    dpos;
  logic                sel_load;
  logic                sel_data;

  // clamp slot count into 1..NUM_SLOTS
  always_comb begin
    if (cfg_n_ports == '0) begin
      n_cl = NCFG_W'(1);
    end else if (cfg_n_ports > NCFG_W'(NUM_SLOTS)) begin
      n_cl = NCFG_W'(NUM_SLOTS);
    end else begin
      n_cl = cfg_n_ports;
    end
    cfg_bits = TOT_W'(n_cl) * TOT_W'(IND_PER_SLOT);
  end

  // line values for the serial clock that is about to be prepared
  always_comb begin
    pre_use  = (state_q == SEQ_IDLE) ? TOT_W'(cfg_pre) : pre_q;
    bits_use = (state_q == SEQ_IDLE) ? cfg_bits : bits_q;
    sel_idx  = (state_q == SEQ_IDLE) ? '0 : bidx_q + TOT_W'(1);
    sel_load = 1'b0;
    sel_data = 1'b0;
    dpos     = '0;
    if (sel_idx == pre_use) begin
      sel_load = 1'b1;
    end else if (sel_idx > pre_use) begin
      dpos = sel_idx - pre_use - TOT_W'(1);
      if (dpos < bits_use) begin
        sel_data = pattern[dpos[BIT_W-1:0]];
      end
    end
  end

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    bidx_d  = bidx_q;
    pre_d   = pre_q;
    bits_d  = bits_q;
    last_d  = last_q;
    clk_d   = clk_q;
    load_d  = load_q;
    data_d  = data_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_LEAD;
          ph_d    = '0;
          bidx_d  = '0;
          pre_d   = TOT_W'(cfg_pre);
          bits_d  = cfg_bits;
          last_d  = TOT_W'(cfg_pre) + cfg_bits + TOT_W'(cfg_post);
          load_d  = sel_load;
          data_d  = sel_data;
        end
      end
      SEQ_LEAD: begin
        if (ph_q == PH_HIGH_END) begin
          state_d = SEQ_RUN;
          ph_d    = '0;
          clk_d   = 1'b1;
        end else begin
          ph_d = ph_q + PH_W'(1);
        end
      end
      SEQ_RUN: begin
        ph_d = ph_q + PH_W'(1);
        if (ph_q == PH_HIGH_END) begin
          clk_d = 1'b0;
        end
        if (ph_q == PH_LOW_SET) begin
          load_d = sel_load;
          data_d = sel_data;
        end
        if (ph_q == PH_END) begin
          ph_d = '0;
          if (bidx_q == last_q) begin
            state_d = SEQ_IDLE;
          end else begin
            bidx_d = bidx_q + TOT_W'(1);
            clk_d  = 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ph_q    <= '0;
      bidx_q  <= '0;
      pre_q   <= '0;
      bits_q  <= '0;
      last_q  <= '0;
      clk_q   <= 1'b0;
      load_q  <= 1'b0;
      data_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      bidx_q  <= bidx_d;
      pre_q   <= pre_d;
      bits_q  <= bits_d;
      last_q  <= last_d;
      clk_q   <= clk_d;
      load_q  <= load_d;
      data_q  <= data_d;
    end
  end

  assign busy    = (state_q != SEQ_IDLE);
  assign sg_clk  = clk_q;
  assign sg_load = load_q;
  assign sg_data = data_q;

endmodule

// File: rtl/sgpio_led_shifter.sv
module sgpio_led_shifter
  import sgpio_led_pkg::*;
#(
  parameter int NUM_PORTS     = 8,
  parameter int NUM_SLOTS     = 8,
  parameter int HALF_DIV      = 5000,
  parameter int CLKCNT_W      = 8,
  parameter int SUBADDR_LIMIT = 15,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int NCFG_W = $clog2(NUM_SLOTS + 1),
  localparam int PAT_W  = IND_PER_SLOT * NUM_SLOTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [PORT_W-1:0]           req_port,
  input  logic [31:0]                 req_status,
  output logic                        req_accept,
  output logic                        req_error,
  output logic                        busy,
  input  logic [NCFG_W-1:0]           cfg_n_ports,
  input  logic [CLKCNT_W-1:0]         cfg_pre_clocks,
  input  logic [CLKCNT_W-1:0]         cfg_post_clocks,
  input  logic [NUM_PORTS*SLOT_W-1:0] cfg_slot_map,
  input  logic [PORT_W-1:0]           rd_port,
  output logic [31:0]                 rd_status,
  output logic                        sg_clk,
  output logic                        sg_load,
  output logic                        sg_data
);

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             start;
  logic [PAT_W-1:0] pattern;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  sgpio_pattern_store #(
    .NUM_PORTS     (NUM_PORTS),
    .NUM_SLOTS     (NUM_SLOTS),
    .SUBADDR_LIMIT (SUBADDR_LIMIT)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_port   (req_port),
    .req_status (req_status),
    .seq_busy   (busy),
    .slot_map   (cfg_slot_map),
    .rd_port    (rd_port),
    .rd_status  (rd_status),
    .pattern    (pattern),
    .start      (start),
    .accept_q   (req_accept),
    .error_q    (req_error)
  );

  sgpio_frame_seq #(
    .NUM_SLOTS (NUM_SLOTS),
    .HALF_DIV  (HALF_DIV),
    .CLKCNT_W  (CLKCNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .pattern     (pattern),
    .cfg_n_ports (cfg_n_ports),
    .cfg_pre     (cfg_pre_clocks),
    .cfg_post    (cfg_post_clocks),
    .busy        (busy),
    .sg_clk      (sg_clk),
    .sg_load     (sg_load),
    .sg_data     (sg_data)
  );

endmodule

// File: rtl/sgpio_led_shifter_chk.sv
module sgpio_led_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic req_accept,
  input logic req_error,
  input logic busy,
  input logic sg_clk,
  input logic sg_load,
  input logic sg_data
);

  assert_load_clk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_load != $past(sg_load)) |-> (!sg_clk && !$past(sg_clk)));

  assert_data_clk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_data != $past(sg_data)) |-> (!sg_clk && !$past(sg_clk)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sg_clk && !sg_load));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> busy);

  assert_reject_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_error |-> !busy);

  assert_busy_from_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> req_accept);

endmodule

bind sgpio_led_shifter sgpio_led_shifter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_accept (req_accept),
  .req_error  (req_error),
  .busy       (busy),
  .sg_clk     (sg_clk),
  .sg_load    (sg_load),
  .sg_data    (sg_data)
);

// File: tb/sgpio_led_shifter_tb.sv
module sgpio_led_shifter_tb;

  localparam int HALF = 3;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_port;
  logic [31:0] req_status;
  logic        req_accept;
  logic        req_error;
  logic        busy;
  logic [3:0]  cfg_n_ports;
  logic [7:0]  cfg_pre_clocks;
  logic [7:0]  cfg_post_clocks;
  logic [23:0] cfg_slot_map;
  logic [2:0]  rd_port;
  logic [31:0] rd_status;
  logic        sg_clk;
  logic        sg_load;
  logic        sg_data;

  int nchecks = 0;
  int nfails  = 0;

  logic [1:0]  exp_q [$];
  logic [23:0] model_pat;
  logic [31:0] model_stat [8];
  int          map_tb [8];

  sgpio_led_shifter #(
    .NUM_PORTS (8),
    .NUM_SLOTS (8),
    .HALF_DIV  (HALF)
  ) u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_port        (req_port),
    .req_status      (req_status),
    .req_accept      (req_accept),
    .req_error       (req_error),
    .busy            (busy),
    .cfg_n_ports     (cfg_n_ports),
    .cfg_pre_clocks  (cfg_pre_clocks),
    .cfg_post_clocks (cfg_post_clocks),
    .cfg_slot_map    (cfg_slot_map),
    .rd_port         (rd_port),
    .rd_status       (rd_status),
    .sg_clk          (sg_clk),
    .sg_load         (sg_load),
    .sg_data         (sg_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
    $finish;
  endtask

  task automatic apply_map();
    for (int p = 0; p < 8; p++) cfg_slot_map[p*3 +: 3] = 3'(map_tb[p]);
  endtask

  // monitor: pops one expected {load,data} per rising serial clock
  logic       prev_clk;
  int         hi_cnt;
  int         lo_cnt;
  logic [1:0] held;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_clk = 1'b0;
      hi_cnt   = 0;
      lo_cnt   = 0;
    end else begin
      if (sg_clk && !prev_clk) begin
        chk(lo_cnt == HALF, "R8", "low time before rise", lo_cnt, HALF);
        lo_cnt = 0;
        hi_cnt = 1;
        held   = {sg_load, sg_data};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "serial clock with nothing expected", 1, 0);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk({sg_load, sg_data} == e, "R6", "load/data at rise", {sg_load, sg_data}, e);
        end
      end else if (sg_clk && prev_clk) begin
        hi_cnt++;
        if ({sg_load, sg_data} != held)
          chk(1'b0, "R8", "lines moved while clock high", {sg_load, sg_data}, held);
      end else if (!sg_clk && prev_clk) begin
        chk(hi_cnt == HALF, "R8", "high time", hi_cnt, HALF);
        lo_cnt = 1;
      end else begin
        if (busy) lo_cnt++;
        else lo_cnt = 0;
      end
      prev_clk = sg_clk;
    end
  end

  task automatic push_frame();
    int nb;
    nb = 3 * int'(cfg_n_ports);
    for (int i = 0; i < int'(cfg_pre_clocks); i++) exp_q.push_back(2'b00);
    exp_q.push_back(2'b10);
    for (int i = 0; i < nb; i++) exp_q.push_back({1'b0, model_pat[i]});
    for (int i = 0; i < int'(cfg_post_clocks); i++) exp_q.push_back(2'b00);
  endtask

  task automatic model_update(input int port, input logic [31:0] st);
    int b;
    b = 3 * map_tb[port];
    model_pat[b]     = st[20] | st[21];
    model_pat[b + 1] = st[19];
    model_pat[b + 2] = st[22];
    model_stat[port] = st;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_req(input int port, input logic [31:0] st, input bit ok, input string req);
    wait_idle();
    if (ok) begin
      model_update(port, st);
      push_frame();
    end
    @(negedge clk);
    req_valid  = 1'b1;
    req_port   = 3'(port);
    req_status = st;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_accept == ok, req, "req_accept", req_accept, ok);
    chk(req_error == !ok, "R4", "req_error", req_error, !ok);
    if (ok) begin
      wait_idle();
      chk(exp_q.size() == 0, "R7", "bits left unsent at frame end", exp_q.size(), 0);
    end else begin
      for (int i = 0; i < 4 * HALF; i++) begin
        @(negedge clk);
        if (busy || sg_clk) chk(1'b0, "R4", "frame after rejected request", busy, 0);
      end
    end
    rd_port = 3'(port);
    #1;
    chk(rd_status == model_stat[port], "R10", "readback", rd_status, model_stat[port]);
  endtask

  initial begin
    #(150000 * 10);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_port = '0;
    req_status = '0;
    rd_port = '0;
    cfg_n_ports = 4'd8;
    cfg_pre_clocks = '0;
    cfg_post_clocks = '0;
    model_pat = '0;
    for (int p = 0; p < 8; p++) begin
      model_stat[p] = '0;
      map_tb[p] = 7 - p;
    end
    apply_map();
    repeat (4) @(negedge clk);
    chk({sg_clk, sg_load, sg_data, busy} == 4'b0, "R1", "outputs in reset",
        {sg_clk, sg_load, sg_data, busy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({sg_clk, sg_load, sg_data, busy, req_accept, req_error} == 6'b0, "R1",
        "outputs after reset", {sg_clk, sg_load, sg_data, busy}, 0);
    for (int p = 0; p < 8; p++) begin
      rd_port = 3'(p);
      #1;
      chk(rd_status == 32'h0, "R1", "readback after reset", rd_status, 0);
    end

    // R2/R3: reversed map, distinct decode paths
    do_req(0, 32'h0010_0000, 1'b1, "R3");
    do_req(1, 32'h0028_0000, 1'b1, "R3");
    do_req(2, 32'h0040_0000, 1'b1, "R2");
    do_req(0, 32'h0000_0000, 1'b1, "R3");

    // R5/R6/R7: short frame with pre and post padding
    cfg_pre_clocks = 8'd2;
    cfg_post_clocks = 8'd3;
    cfg_n_ports = 4'd3;
    do_req(5, 32'h0078_0000, 1'b1, "R5");
    cfg_n_ports = 4'd1;
    cfg_pre_clocks = 8'd1;
    cfg_post_clocks = 8'd0;
    do_req(7, 32'h0020_0000, 1'b1, "R6");

    // R4: sub-address boundary
    cfg_n_ports = 4'd8;
    do_req(3, 32'h0070_0F00, 1'b0, "R4");
    do_req(4, 32'h0040_0E00, 1'b1, "R4");

    // R9: request during a frame is dropped
    wait_idle();
    model_update(6, 32'h0080_0000 | 32'h0010_0000);
    push_frame();
    @(negedge clk);
    req_valid = 1'b1; req_port = 3'd6; req_status = 32'h0010_0000;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_accept == 1'b1, "R9", "first accept", req_accept, 1);
    repeat (HALF + 2) @(negedge clk);
    chk(busy == 1'b1, "R9", "busy during frame", busy, 1);
    req_valid = 1'b1; req_port = 3'd3; req_status = 32'h0040_0000;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req_accept, req_error} == 2'b00, "R9", "response while busy", {req_accept, req_error}, 0);
    wait_idle();
    chk(exp_q.size() == 0, "R7", "bits left unsent", exp_q.size(), 0);
    rd_port = 3'd3;
    #1;
    chk(rd_status == model_stat[3], "R9", "ignored request readback", rd_status, model_stat[3]);

    // R2: remap port 3 to slot 0, pattern check through next frame
    map_tb[3] = 0;
    apply_map();
    do_req(3, 32'h0048_0000, 1'b1, "R2");
    do_req(1, 32'h0020_0000, 1'b1, "R10");

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule